// File: doc/BRIEF.md
# One-Shot Pulse Timer

This block is a 16-bit up-counter that emits a single pulse per trigger. A trigger comes either from a one-cycle software strobe or from a selectable edge on an asynchronous external input. An accepted trigger clears the counter and arms a pulse sequence.

Two compare values bound the pulse. The smaller one raises the output and the larger one drops it, so the order in which the two registers are programmed does not matter. Once the pulse ends, the counter keeps running with the output low until the next trigger. Any trigger that arrives while a pulse sequence is armed or running is discarded.

Each compare register has its own one-cycle match strobe. The counter steps only on cycles where the count-enable input is high. A mode field of zero parks the whole block.

Top module: `one_shot_pulse_timer`

## Requirements
- R1: With `run_mode` = 2'b00 the counter is held at 0, `pulse_out` is low, both match strobes stay low, and triggers are not accepted. Any nonzero `run_mode` lets the block run.
- R2: While running, the counter advances by one only on clock edges where `cnt_en` is high. It wraps from 16'hFFFF to 16'h0000.
- R3: A `sw_trig` strobe that is accepted sets the counter to 0 at the next clock edge, regardless of `cnt_en`, and arms a pulse sequence.
- R4: `ext_trig` passes through two synchronizing flops before its edge is detected. The edge is selected by `edge_sel`: 2'b00 falling, 2'b01 rising, 2'b10 both, 2'b11 none. An input change made before clock edge k is accepted at edge k+2.
- R5: With `cmp_first` < `cmp_second`, `pulse_out` rises after the first enabled edge at which the count equals `cmp_first`. It falls after the enabled edge at which the count equals `cmp_second`.
- R6: With `cmp_first` > `cmp_second`, the roles swap. The pulse rises on the `cmp_second` match and falls on the `cmp_first` match.
- R7: With `cmp_first` = `cmp_second`, no pulse is produced. The armed sequence ends at that match, so a later trigger is accepted again.
- R8: A trigger (software or external) is ignored from its acceptance until the deactivating match. In that window the count and the output are undisturbed.
- R9: `match_first_irq` (`match_second_irq`) is high for exactly the one cycle after each enabled edge at which the count equals `cmp_first` (`cmp_second`), while running, whether or not a pulse is armed.
- R10: After reset, the counter is 0 and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en | input | 1 | Count-clock enable |
| run_mode | input | 2 | 00 stopped, otherwise running |
| sw_trig | input | 1 | Software trigger strobe |
| ext_trig | input | 1 | Asynchronous external trigger |
| edge_sel | input | 2 | Valid edge of ext_trig |
| cmp_first | input | 16 | First compare value |
| cmp_second | input | 16 | Second compare value |
| pulse_out | output | 1 | One-shot pulse |
| match_first_irq | output | 1 | Match strobe for cmp_first |
| match_second_irq | output | 1 | Match strobe for cmp_second |

## Verification
Every result is registered, so `pulse_out` and both strobes reflect the count that was present at the previous clock edge. A software trigger shows a zero count one edge later. An external edge takes effect two edges after it is applied, because it passes through the synchronizer. The bench drives inputs and samples outputs on the falling clock edge. Between those two actions it steps a cycle model written from the requirements by one edge, so every comparison lands in the cycle in which the result is due. Random traffic, with small compare values and a sparse enable, is combined with directed cases: equal compares, swapped order, retrigger during a pulse, every edge setting, and a full counter wrap.

// File: rtl/ospt_pkg.sv
// Package: shared types for the one-shot pulse timer.
// Assumes: counter width fixed by CNT_W; edge select encoding is 2 bits.
package ospt_pkg;
    localparam int CNT_W = 16;

    typedef enum logic [1:0] {
        EDGE_FALL = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_BOTH = 2'b10,
        EDGE_NONE = 2'b11
    } edge_sel_t;
endpackage

// File: rtl/ospt_edge_detect.sv
// Module: synchronizes an asynchronous trigger and flags the selected edge.
// Assumes: ext_i is asynchronous to clk; SYNC_STAGES >= 2.
module ospt_edge_detect
    import ospt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ext_i,
    input  edge_sel_t sel_i,
    output logic      edge_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   cur;
    logic                   rise;
    logic                   fall;

    // Shift register synchronizer, plus one flop of history for edge compare.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], ext_i};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign cur  = sync_q[SYNC_STAGES-1];
    assign rise = cur & ~prev_q;
    assign fall = ~cur & prev_q;

    // Select which transition counts as a trigger.
    always_comb begin
        unique case (sel_i)
            EDGE_FALL: edge_o = fall;
            EDGE_RISE: edge_o = rise;
            EDGE_BOTH: edge_o = rise | fall;
            default:   edge_o = 1'b0;
        endcase
    end

    // History flop must trail the synchronizer output by one cycle.
    assert_history_trails_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> prev_q == $past(sync_q[SYNC_STAGES-1]));
endmodule

// File: rtl/ospt_counter.sv
// Module: free-running up-counter with clear on stop or accepted trigger.
// Assumes: accept_i is only raised while run_i is high.
module ospt_counter
    import ospt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             en_i,
    input  logic             accept_i,
    output logic [CNT_W-1:0] cnt_o
);
    // Clear when stopped or triggered, otherwise step on enable (wraps).
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_o <= '0;
        else if (!run_i || accept_i)
            cnt_o <= '0;
        else if (en_i)
            cnt_o <= cnt_o + 1'b1;
    end

    assert_clear_when_stopped_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> cnt_o == '0);
    assert_hold_without_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !en_i && !accept_i) |=> $stable(cnt_o));
    assert_trigger_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        accept_i |=> cnt_o == '0);
endmodule

// File: rtl/ospt_output_ctrl.sv
// Module: orders the two compare values, drives the pulse and match strobes.
// Assumes: cnt_i comes from the counter; accept_i only when busy_o is low.
module ospt_output_ctrl
    import ospt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             en_i,
    input  logic             accept_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] cmp_a_i,
    input  logic [CNT_W-1:0] cmp_b_i,
    output logic             busy_o,
    output logic             pulse_o,
    output logic             irq_a_o,
    output logic             irq_b_o
);
    logic [CNT_W-1:0] lo_val;
    logic [CNT_W-1:0] hi_val;
    logic             hit_a;
    logic             hit_b;
    logic             step;

    // Smaller compare opens the pulse, larger one closes it.
    assign lo_val = (cmp_a_i < cmp_b_i) ? cmp_a_i : cmp_b_i;
    assign hi_val = (cmp_a_i < cmp_b_i) ? cmp_b_i : cmp_a_i;
    assign step   = run_i & en_i;
    assign hit_a  = step & (cnt_i == cmp_a_i);
    assign hit_b  = step & (cnt_i == cmp_b_i);

    // Registered match strobes, one per compare register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_a_o <= 1'b0;
            irq_b_o <= 1'b0;
        end else begin
            irq_a_o <= hit_a;
            irq_b_o <= hit_b;
        end
    end

    // Busy/pulse sequencing; closing match wins over opening match.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            busy_o  <= 1'b0;
            pulse_o <= 1'b0;
        end else if (accept_i) begin
            busy_o  <= 1'b1;
            pulse_o <= 1'b0;
        end else if (busy_o && step && cnt_i == hi_val) begin
            busy_o  <= 1'b0;
            pulse_o <= 1'b0;
        end else if (busy_o && step && cnt_i == lo_val) begin
            pulse_o <= 1'b1;
        end
    end

    assert_pulse_within_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> busy_o);
    assert_accept_only_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        accept_i |-> !busy_o);
    assert_stopped_output_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !pulse_o && !irq_a_o && !irq_b_o);
endmodule

// File: rtl/one_shot_pulse_timer.sv
// Module: top of the one-shot pulse timer; wires trigger, counter and output.
// Assumes: single clock, synchronous active-low reset, sw_trig one cycle wide.
module one_shot_pulse_timer
    import ospt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic [1:0]       run_mode,
    input  logic             sw_trig,
    input  logic             ext_trig,
    input  logic [1:0]       edge_sel,
    input  logic [CNT_W-1:0] cmp_first,
    input  logic [CNT_W-1:0] cmp_second,
    output logic             pulse_out,
    output logic             match_first_irq,
    output logic             match_second_irq
);
    logic             run;
    logic             ext_edge;
    logic             busy;
    logic             accept;
    logic [CNT_W-1:0] cnt;

    assign run    = |run_mode;
    assign accept = run & ~busy & (sw_trig | ext_edge);

    ospt_edge_detect #(.SYNC_STAGES(2)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .ext_i  (ext_trig),
        .sel_i  (edge_sel_t'(edge_sel)),
        .edge_o (ext_edge)
    );

    ospt_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run),
        .en_i     (cnt_en),
        .accept_i (accept),
        .cnt_o    (cnt)
    );

    ospt_output_ctrl u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run),
        .en_i     (cnt_en),
        .accept_i (accept),
        .cnt_i    (cnt),
        .cmp_a_i  (cmp_first),
        .cmp_b_i  (cmp_second),
        .busy_o   (busy),
        .pulse_o  (pulse_out),
        .irq_a_o  (match_first_irq),
        .irq_b_o  (match_second_irq)
    );

    assert_reset_state_R10: assert property (@(posedge clk)
        !rst_n |=> !pulse_out && !match_first_irq && !match_second_irq);
endmodule

// File: tb/test_one_shot_pulse_timer.sv
// Bench: random plus directed stimulus against a cycle model of the requirements.
module test_one_shot_pulse_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0;
    logic [1:0]  run_mode = 2'b00;
    logic        sw_trig = 1'b0;
    logic        ext_trig = 1'b0;
    logic [1:0]  edge_sel = 2'b01;
    logic [15:0] cmp_first = 16'd0;
    logic [15:0] cmp_second = 16'd0;
    logic        pulse_out, match_first_irq, match_second_irq;

    int n_checks = 0;
    int n_fail = 0;
    string tag = "R10";

    // Model state
    logic        m_s1, m_s2, m_prev, m_busy, m_pulse, m_ia, m_ib;
    logic [15:0] m_cnt;

    always #10 clk = ~clk;

    one_shot_pulse_timer i_one_shot_pulse_timer (
        .clk, .rst_n, .cnt_en, .run_mode, .sw_trig, .ext_trig, .edge_sel,
        .cmp_first, .cmp_second, .pulse_out, .match_first_irq, .match_second_irq
    );

    function automatic logic edge_of(logic cur, logic prv, logic [1:0] s);
        case (s)
            2'b00: return ~cur & prv;
            2'b01: return cur & ~prv;
            2'b10: return cur ^ prv;
            default: return 1'b0;
        endcase
    endfunction

    task automatic model_reset();
        m_s1 = 0; m_s2 = 0; m_prev = 0; m_busy = 0; m_pulse = 0;
        m_ia = 0; m_ib = 0; m_cnt = 0;
    endtask

    // Advance the model by one clock edge using the inputs held during it.
    task automatic model_step();
        logic run, acc, step;
        logic [15:0] lo, hi, c;
        run  = run_mode != 2'b00;
        acc  = run && !m_busy && (sw_trig || edge_of(m_s2, m_prev, edge_sel));
        step = run && cnt_en;
        lo   = (cmp_first < cmp_second) ? cmp_first : cmp_second;
        hi   = (cmp_first < cmp_second) ? cmp_second : cmp_first;
        c    = m_cnt;
        m_ia = step && c == cmp_first;
        m_ib = step && c == cmp_second;
        if (!run) begin
            m_cnt = 0; m_busy = 0; m_pulse = 0;
        end else if (acc) begin
            m_cnt = 0; m_busy = 1; m_pulse = 0;
        end else begin
            if (cnt_en) m_cnt = c + 1'b1;
            if (m_busy && step && c == hi) begin
                m_busy = 0; m_pulse = 0;
            end else if (m_busy && step && c == lo) m_pulse = 1;
        end
        m_prev = m_s2; m_s2 = m_s1; m_s1 = ext_trig;
    endtask

    task automatic check_outputs();
        n_checks++;
        if (pulse_out !== m_pulse || match_first_irq !== m_ia || match_second_irq !== m_ib) begin
            n_fail++;
            $display("FAIL %s: pulse/irqA/irqB actual %b%b%b expected %b%b%b at %0t",
                     tag, pulse_out, match_first_irq, match_second_irq,
                     m_pulse, m_ia, m_ib, $time);
        end
    endtask

    // One cycle: wait for falling edge, step model, compare.
    task automatic cycle();
        @(negedge clk);
        model_step();
        check_outputs();
        sw_trig = 1'b0;
    endtask

    task automatic run_cycles(int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic pulse_sw();
        sw_trig = 1'b1;
        cycle();
    endtask

    initial begin
        #4000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        tag = "R10"; check_outputs();

        // R1: stopped mode ignores triggers
        tag = "R1"; cnt_en = 1; cmp_first = 0; cmp_second = 3;
        pulse_sw(); run_cycles(6);

        // R3 / R5: software trigger, N < M
        tag = "R5"; run_mode = 2'b01; cmp_first = 4; cmp_second = 9;
        run_cycles(2); tag = "R3"; pulse_sw(); tag = "R5"; run_cycles(14);

        // R6: swapped order
        tag = "R6"; cmp_first = 10; cmp_second = 3; pulse_sw(); run_cycles(14);

        // R8: retrigger mid-pulse ignored
        tag = "R8"; cmp_first = 2; cmp_second = 12; pulse_sw(); run_cycles(5);
        pulse_sw(); ext_trig = ~ext_trig; edge_sel = 2'b10; run_cycles(12);

        // R7: equal compares, no pulse, then re-arm works
        tag = "R7"; cmp_first = 5; cmp_second = 5; pulse_sw(); run_cycles(8);
        cmp_second = 7; pulse_sw(); run_cycles(10);

        // R4: every edge selection
        tag = "R4"; cmp_first = 1; cmp_second = 4;
        for (int s = 0; s < 4; s++) begin
            edge_sel = s[1:0];
            run_cycles(8);
            ext_trig = ~ext_trig; run_cycles(8);
            ext_trig = ~ext_trig; run_cycles(8);
        end

        // R2: enable gating, then a full wrap through FFFF
        tag = "R2"; edge_sel = 2'b11; cmp_first = 16'hFFFF; cmp_second = 16'h0001;
        pulse_sw();
        for (int i = 0; i < 40; i++) begin cnt_en = i[0]; cycle(); end
        cnt_en = 1; run_cycles(65545);

        // R9: random traffic with irq checks
        tag = "R9";
        for (int i = 0; i < 60000; i++) begin
            cnt_en   = ($urandom % 4) != 0;
            if (($urandom % 500) == 0) run_mode = 2'b00;
            else if (run_mode == 2'b00) run_mode = 2'($urandom % 3 + 1);
            if (($urandom % 200) == 0) begin
                cmp_first  = 16'($urandom % 40);
                cmp_second = 16'($urandom % 40);
            end
            if (($urandom % 300) == 0) edge_sel = 2'($urandom % 4);
            if (($urandom % 37) == 0) ext_trig = ~ext_trig;
            sw_trig = ($urandom % 61) == 0;
            cycle();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule